// File: doc/BRIEF.md
# Packed Decimal Shift and Round

This block moves the digits of a signed packed-decimal number left or right by a signed digit count. The operand is up to `MAX_BYTES` bytes long: two digits per byte, with the last nibble holding the sign. Operands are right-justified on the input bus. The sign sits in bits [3:0], and digit i (i = 0 is the least significant) sits in bits [4i+7:4i+4]. A number of L bytes carries 2L-1 digits. A left shift multiplies by a power of ten and keeps the low digits. A right shift divides by a power of ten and then rounds: a chosen rounding digit is added to the most significant digit that was dropped, and any decimal carry ripples back into the kept digits.

Work is digit-serial, one digit position per clock. A request enters on a valid/ready handshake: `in_ready` is high only while the block is idle, and a request is taken on a clock edge where both `in_valid` and `in_ready` are high. The answer appears with `out_valid` and is held, unchanged, until the consumer raises `out_ready`. Back-pressure therefore stalls the block without any loss, and no new request is taken while an answer waits. Besides the shifted number, the block returns a 2-bit condition code and a data-error flag for malformed operands.

Top module: `pdsr_shift_round`

## Requirements
- R1: A positive amount s shifts left. Zero digits enter at the least significant end, and the result digits equal (N * 10^s) mod 10^n, where n = 2*length-1.
- R2: The amount is a 6-bit two's-complement value in the range -32..31. Values with bit 5 set shift right by the magnitude, and 0 leaves the digits unchanged.
- R3: A right shift by r keeps floor(N / 10^r). The rounding digit (4 bits, 0..15) is added to the most significant dropped digit, and a sum of 10 or more adds one to the kept value. With a rounding digit of 0 the result truncates, with 5 it rounds half up, and with 9 it rounds up.
- R4: On a valid result with no lost digits, the condition code is 0 for a zero result, 1 for a nonzero negative result (sign 0xD) and 2 for a nonzero positive result.
- R5: If a left shift pushes any nonzero digit past the top of the n-digit field, the condition code is 3. The truncated digits are still returned.
- R6: The output sign nibble is the input sign (0xC, 0xD or 0xF). The only exception is a zero result, which always carries 0xC.
- R7: A sign nibble other than 0xC, 0xD or 0xF sets the data-error flag. An erroneous answer returns a zero number and condition code 0.
- R8: Any digit nibble above 9 within the n-digit field sets the data-error flag.
- R9: A length outside 1..MAX_BYTES sets the data-error flag.
- R10: Input nibbles above bit 8*length-1 are ignored, and the result carries zeros there.
- R11: `in_ready` is high only when idle. While `out_valid` is high and `out_ready` is low, `out_valid`, the number, the condition code and the error flag hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block idle, request accepted on this edge if valid |
| in_num | input | 8*MAX_BYTES | Packed operand, right-justified, sign in [3:0] |
| in_len | input | $clog2(MAX_BYTES)+2 | Operand length in bytes |
| in_amt | input | 6 | Signed digit shift amount |
| in_rnd | input | 4 | Rounding digit for right shifts |
| out_valid | output | 1 | Answer valid (done) |
| out_ready | input | 1 | Consumer takes the answer |
| out_num | output | 8*MAX_BYTES | Packed result |
| out_cc | output | 2 | Condition code |
| out_err | output | 1 | Data error on the answered request |

## Verification
The hardest case to reach is a rounding carry that ripples through every kept digit, which needs an operand whose kept digits are all nines. The stimulus always includes the all-nines value for each length and crosses it with every shift amount and with rounding digits both below and above the carry threshold. Right shifts equal to, and beyond, the digit count test whether the single dropped digit in the top position rounds correctly. Junk nibbles, including codes above 9, are placed beyond the field for short operands, so that ignoring them can be checked in the same sweep.

// File: rtl/pdsr_pkg.sv
package pdsr_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SHIFT,
    S_ROUND,
    S_CARRY,
    S_DONE
  } state_t;

  typedef enum logic [1:0] {
    OP_HOLD,
    OP_LOAD,
    OP_STEP,
    OP_INC
  } dp_op_t;

  localparam logic [3:0] SGN_PLUS  = 4'hC;
  localparam logic [3:0] SGN_MINUS = 4'hD;
  localparam logic [3:0] SGN_PREF  = 4'hF;
endpackage

// File: rtl/pdsr_check.sv
module pdsr_check import pdsr_pkg::*; #(
  parameter int MAX_BYTES = 16,
  parameter int W         = 8 * MAX_BYTES,
  parameter int D         = 2 * MAX_BYTES - 1,
  parameter int LEN_W     = $clog2(MAX_BYTES) + 2,
  parameter int DIG_W     = $clog2(D + 1)
) (
  input  logic [W-1:0]     num,
  input  logic [LEN_W-1:0] len,
  output logic             ok,
  output logic [DIG_W-1:0] n_dig,
  output logic [4*D-1:0]   masked
);
  logic len_ok;
  logic sign_ok;
  logic bad_dig;
  int   n_i;

  assign len_ok  = (len != '0) && (len <= LEN_W'(MAX_BYTES));
  assign sign_ok = (num[3:0] == SGN_PLUS) || (num[3:0] == SGN_MINUS) ||
                   (num[3:0] == SGN_PREF);

  always_comb begin
    n_i     = len_ok ? (2 * int'(len) - 1) : 0;
    bad_dig = 1'b0;
    masked  = '0;
    for (int i = 0; i < D; i++) begin
      if (i < n_i) begin
        masked[4*i +: 4] = num[4*i+4 +: 4];
        if (num[4*i+4 +: 4] > 4'd9) bad_dig = 1'b1;
      end
    end
  end

  assign n_dig = DIG_W'(n_i);
  assign ok    = len_ok && sign_ok && !bad_dig;
endmodule

// File: rtl/pdsr_datapath.sv
module pdsr_datapath import pdsr_pkg::*; #(
  parameter int D     = 31,
  parameter int DIG_W = $clog2(D + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dp_op_t           op,
  input  logic             dir_left,
  input  logic [DIG_W-1:0] n_dig,
  input  logic [4*D-1:0]   load_dig,
  input  logic [DIG_W-1:0] idx,
  output logic [4*D-1:0]   digits,
  output logic             lost_nz,
  output logic [3:0]       last_out,
  output logic             inc_more
);
  logic [DIG_W-1:0] n_q;
  logic [4*D-1:0]   lft;
  logic [4*D-1:0]   rgt;
  logic [4*D-1:0]   incd;
  logic [3:0]       top;
  logic [3:0]       cur;

  always_comb begin
    lft = '0;
    top = '0;
    cur = '0;
    incd = digits;
    for (int i = 1; i < D; i++) begin
      if (i < int'(n_q)) lft[4*i +: 4] = digits[4*(i-1) +: 4];
    end
    for (int i = 0; i < D; i++) begin
      if (i + 1 == int'(n_q)) top = digits[4*i +: 4];
      if (i == int'(idx)) begin
        cur = digits[4*i +: 4];
        incd[4*i +: 4] = (digits[4*i +: 4] == 4'd9) ? 4'd0 : digits[4*i +: 4] + 4'd1;
      end
    end
  end

  assign rgt      = {4'd0, digits[4*D-1:4]};
  assign inc_more = (cur == 4'd9);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      digits   <= '0;
      lost_nz  <= 1'b0;
      last_out <= '0;
      n_q      <= '0;
    end else begin
      case (op)
        OP_LOAD: begin
          digits   <= load_dig;
          lost_nz  <= 1'b0;
          last_out <= '0;
          n_q      <= n_dig;
        end
        OP_STEP: begin
          if (dir_left) begin
            digits  <= lft;
            lost_nz <= lost_nz | (top != 4'd0);
          end else begin
            digits   <= rgt;
            last_out <= digits[3:0];
          end
        end
        OP_INC:  digits <= incd;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pdsr_ctrl.sv
module pdsr_ctrl import pdsr_pkg::*; #(
  parameter int D     = 31,
  parameter int DIG_W = $clog2(D + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  input  logic             ok,
  input  logic [5:0]       amt,
  input  logic [3:0]       rnd,
  input  logic [3:0]       sign_in,
  input  logic [3:0]       last_out,
  input  logic             inc_more,
  output logic             in_ready,
  output logic             out_valid,
  output dp_op_t           op,
  output logic             dir_left,
  output logic [DIG_W-1:0] idx,
  output logic             err_q,
  output logic [3:0]       sign_q
);
  state_t     state;
  logic [5:0] cnt;
  logic [5:0] mag;
  logic [3:0] rnd_q;
  logic [4:0] rsum;

  assign mag       = amt[5] ? (~amt + 6'd1) : amt;
  assign rsum      = {1'b0, rnd_q} + {1'b0, last_out};
  assign in_ready  = (state == S_IDLE);
  assign out_valid = (state == S_DONE);

  always_comb begin
    op = OP_HOLD;
    case (state)
      S_IDLE:  if (in_valid) op = OP_LOAD;
      S_SHIFT: op = OP_STEP;
      S_CARRY: op = OP_INC;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      dir_left <= 1'b0;
      rnd_q    <= '0;
      idx      <= '0;
      err_q    <= 1'b0;
      sign_q   <= SGN_PLUS;
    end else begin
      case (state)
        S_IDLE: if (in_valid) begin
          err_q    <= !ok;
          sign_q   <= sign_in;
          rnd_q    <= rnd;
          dir_left <= !amt[5];
          cnt      <= mag;
          state    <= (!ok || amt == 6'd0) ? S_DONE : S_SHIFT;
        end
        S_SHIFT: begin
          cnt <= cnt - 6'd1;
          if (cnt == 6'd1) state <= dir_left ? S_DONE : S_ROUND;
        end
        S_ROUND: begin
          idx <= '0;
          state <= (rsum >= 5'd10) ? S_CARRY : S_DONE;
        end
        S_CARRY: begin
          if (inc_more && idx != DIG_W'(D - 1)) idx <= idx + DIG_W'(1);
          else state <= S_DONE;
        end
        S_DONE:  if (out_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pdsr_shift_round.sv
module pdsr_shift_round import pdsr_pkg::*; #(
  parameter int MAX_BYTES = 16,
  localparam int W        = 8 * MAX_BYTES,
  localparam int D        = 2 * MAX_BYTES - 1,
  localparam int LEN_W    = $clog2(MAX_BYTES) + 2,
  localparam int DIG_W    = $clog2(D + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_num,
  input  logic [LEN_W-1:0] in_len,
  input  logic [5:0]       in_amt,
  input  logic [3:0]       in_rnd,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_num,
  output logic [1:0]       out_cc,
  output logic             out_err
);
  logic             ok;
  logic [DIG_W-1:0] n_dig;
  logic [4*D-1:0]   masked;
  logic [4*D-1:0]   digits;
  logic             lost_nz;
  logic [3:0]       last_out;
  logic             inc_more;
  dp_op_t           op;
  logic             dir_left;
  logic [DIG_W-1:0] idx;
  logic             err_q;
  logic [3:0]       sign_q;
  logic             is_zero;

  pdsr_check #(.MAX_BYTES(MAX_BYTES), .W(W), .D(D), .LEN_W(LEN_W), .DIG_W(DIG_W)) u_check (
    .num(in_num), .len(in_len), .ok(ok), .n_dig(n_dig), .masked(masked)
  );

  pdsr_datapath #(.D(D), .DIG_W(DIG_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .op(op), .dir_left(dir_left), .n_dig(n_dig),
    .load_dig(masked), .idx(idx), .digits(digits), .lost_nz(lost_nz),
    .last_out(last_out), .inc_more(inc_more)
  );

  pdsr_ctrl #(.D(D), .DIG_W(DIG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .ok(ok), .amt(in_amt), .rnd(in_rnd), .sign_in(in_num[3:0]),
    .last_out(last_out), .inc_more(inc_more), .in_ready(in_ready),
    .out_valid(out_valid), .op(op), .dir_left(dir_left), .idx(idx),
    .err_q(err_q), .sign_q(sign_q)
  );

  assign is_zero = (digits == '0);
  assign out_err = out_valid && err_q;
  assign out_num = err_q ? '0 : {digits, (is_zero ? SGN_PLUS : sign_q)};

  always_comb begin
    if (err_q)                 out_cc = 2'd0;
    else if (lost_nz)          out_cc = 2'd3;
    else if (is_zero)          out_cc = 2'd0;
    else if (sign_q == SGN_MINUS) out_cc = 2'd1;
    else                       out_cc = 2'd2;
  end
endmodule

// File: rtl/pdsr_checker.sv
module pdsr_checker #(
  parameter int W = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_num,
  input logic [1:0]   out_cc,
  input logic         out_err
);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_num) && $stable(out_cc) && $stable(out_err));

  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_cc == 2'd0 && out_num == '0);

  p_zero_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err && out_cc == 2'd0 |-> out_num == {{(W-4){1'b0}}, 4'hC});

  p_neg_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err && out_cc == 2'd1 |-> out_num[3:0] == 4'hD);

  p_sign_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> (out_num[3:0] == 4'hC || out_num[3:0] == 4'hD || out_num[3:0] == 4'hF));
endmodule

bind pdsr_shift_round pdsr_checker #(.W(8 * MAX_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_num(out_num), .out_cc(out_cc), .out_err(out_err)
);

// File: tb/sim_pdsr_shift_round.sv
module sim_pdsr_shift_round;
  localparam int MB = 3;
  localparam int W  = 8 * MB;
  localparam int ND = 2 * MB - 1;
  localparam int LW = $clog2(MB) + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_num = '0;
  logic [LW-1:0] in_len = '0;
  logic [5:0]    in_amt = '0;
  logic [3:0]    in_rnd = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [W-1:0]  out_num;
  logic [1:0]    out_cc;
  logic          out_err;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pdsr_shift_round #(.MAX_BYTES(MB)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_num(in_num), .in_len(in_len), .in_amt(in_amt), .in_rnd(in_rnd),
    .out_valid(out_valid), .out_ready(out_ready), .out_num(out_num),
    .out_cc(out_cc), .out_err(out_err)
  );

  function automatic longint p10(int e);
    longint r = 1;
    for (int i = 0; i < e; i++) r = r * 10;
    return r;
  endfunction

  function automatic logic [W-1:0] pack(longint v, logic [3:0] s);
    logic [W-1:0] o = '0;
    o[3:0] = s;
    for (int i = 0; i < ND; i++) o[4*i+4 +: 4] = 4'((v / p10(i)) % 10);
    return o;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model(longint nv, int n, int s, int rnd, logic [3:0] sg,
                       output logic [W-1:0] en, output logic [1:0] ec);
    longint res;
    longint lost;
    bit ov = 0;
    if (s >= 0) begin
      if (s >= n) begin res = 0; ov = (nv != 0); end
      else begin
        res = (nv % p10(n - s)) * p10(s);
        ov = ((nv / p10(n - s)) != 0);
      end
    end else begin
      int r = -s;
      if (r > n) begin res = 0; lost = 0; end
      else if (r == n) begin res = 0; lost = nv / p10(n - 1); end
      else begin res = nv / p10(r); lost = (nv / p10(r - 1)) % 10; end
      if (rnd + lost >= 10) res = res + 1;
    end
    en = pack(res, (res == 0) ? 4'hC : sg);
    if (ov) ec = 2'd3;
    else if (res == 0) ec = 2'd0;
    else if (sg == 4'hD) ec = 2'd1;
    else ec = 2'd2;
  endtask

  task automatic do_op(logic [W-1:0] num, logic [LW-1:0] len, logic [5:0] amt,
                       logic [3:0] rnd, output logic [W-1:0] r, output logic [1:0] c,
                       output logic e);
    int guard = 0;
    @(negedge clk);
    while (!in_ready && guard < 200) begin @(negedge clk); guard++; end
    in_valid = 1'b1; in_num = num; in_len = len; in_amt = amt; in_rnd = rnd;
    @(negedge clk);
    in_valid = 1'b0;
    guard = 0;
    while (!out_valid && guard < 200) begin @(negedge clk); guard++; end
    if (!out_valid) check("R11", "answer timeout", 0, 1);
    r = out_num; c = out_cc; e = out_err;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run_valid(longint nv, int len, int a, int rnd, logic [3:0] sg,
                           logic [W-1:0] junk);
    logic [W-1:0] r, en;
    logic [1:0] c, ec;
    logic e;
    int s = (a >= 32) ? a - 64 : a;
    string tg;
    tg = (s > 0) ? "R1" : (s < 0) ? "R3" : "R2";
    model(nv, 2 * len - 1, s, rnd, sg, en, ec);
    do_op(pack(nv, sg) | junk, LW'(len), 6'(a), 4'(rnd), r, c, e);
    check(tg, "result/R6", longint'(r), longint'(en));
    check((ec == 2'd3) ? "R5" : "R4", "cc", longint'(c), longint'(ec));
    check("R8", "no error", longint'(e), 0);
  endtask

  task automatic run_err(string req, logic [W-1:0] num, int len);
    logic [W-1:0] r;
    logic [1:0] c;
    logic e;
    do_op(num, LW'(len), 6'd2, 4'd5, r, c, e);
    check(req, "err flag", longint'(e), 1);
    check("R7", "err result", longint'(r), 0);
    check("R7", "err cc", longint'(c), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R11 watchdog actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r, r0;
    logic [1:0] c;
    logic e;
    int hold_ok;
    repeat (3) @(negedge clk);
    check("R11", "reset ready", longint'(in_ready), 1);
    check("R11", "reset valid", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: direction from the sign bit of the amount
    do_op(pack(123, 4'hC), 4'd2, 6'h3F, 4'd0, r, c, e);
    check("R2", "minus one", longint'(r), longint'(pack(12, 4'hC)));
    do_op(pack(123, 4'hC), 4'd2, 6'h01, 4'd0, r, c, e);
    check("R2", "plus one", longint'(r), longint'(pack(230, 4'hC)));
    check("R5", "lost digit cc", longint'(c), 3);
    do_op(pack(999, 4'hD), 4'd2, 6'h20, 4'd9, r, c, e);
    check("R2", "minus 32", longint'(r), longint'(pack(0, 4'hC)));

    // R3: rounding digits 0, 5, 9
    do_op(pack(125, 4'hC), 4'd2, 6'h3F, 4'd0, r, c, e);
    check("R3", "truncate", longint'(r), longint'(pack(12, 4'hC)));
    do_op(pack(125, 4'hC), 4'd2, 6'h3F, 4'd5, r, c, e);
    check("R3", "half up", longint'(r), longint'(pack(13, 4'hC)));
    do_op(pack(124, 4'hC), 4'd2, 6'h3F, 4'd5, r, c, e);
    check("R3", "below half", longint'(r), longint'(pack(12, 4'hC)));
    do_op(pack(121, 4'hC), 4'd2, 6'h3F, 4'd9, r, c, e);
    check("R3", "round up", longint'(r), longint'(pack(13, 4'hC)));

    // R6: negative zero written positive
    do_op(pack(0, 4'hD), 4'd3, 6'd0, 4'd0, r, c, e);
    check("R6", "neg zero sign", longint'(r), longint'(pack(0, 4'hC)));
    check("R4", "zero cc", longint'(c), 0);

    // R11: back-pressure hold and busy ready
    @(negedge clk);
    in_valid = 1'b1; in_num = pack(4321, 4'hD); in_len = 4'd3; in_amt = 6'h3E; in_rnd = 4'd5;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11", "ready after accept", longint'(in_ready), 0);
    while (!out_valid) @(negedge clk);
    r0 = out_num;
    hold_ok = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (!out_valid || out_num != r0) hold_ok = 0;
    end
    check("R11", "hold under back-pressure", hold_ok, 1);
    check("R3", "held value", longint'(r0), longint'(pack(43, 4'hD)));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;

    // R7: illegal sign nibbles
    for (int s = 0; s < 16; s++) begin
      if (s != 12 && s != 13 && s != 15) run_err("R7", pack(12, 4'(s)), 2);
    end
    // R8: digit above 9 in every field position
    for (int i = 0; i < ND; i++) begin
      logic [W-1:0] v = pack(0, 4'hC);
      v[4*i+4 +: 4] = 4'hA + 4'(i % 6);
      run_err("R8", v, 3);
    end
    // R9: lengths out of range
    run_err("R9", pack(5, 4'hC), 0);
    for (int l = MB + 1; l < (1 << LW); l++) run_err("R9", pack(5, 4'hC), l);

    // Exhaustive single-byte sweep with junk above the field (R10)
    for (int d = 0; d < 10; d++) begin
      for (int a = 0; a < 64; a++) begin
        for (int rk = 0; rk < 3; rk++) begin
          logic [3:0] sg = (d % 3 == 0) ? 4'hC : (d % 3 == 1) ? 4'hD : 4'hF;
          int rnd = (rk == 0) ? 0 : (rk == 1) ? 5 : 9;
          run_valid(d, 1, a, rnd, sg, 24'h9AF500);
        end
      end
    end
    do_op(pack(7, 4'hC) | 24'hEBA000, 4'd1, 6'd0, 4'd0, r, c, e);
    check("R10", "upper nibbles zero", longint'(r[W-1:8]), 0);
    check("R10", "no error from junk", longint'(e), 0);

    // Patterned sweep over longer operands, including all nines
    for (int len = 2; len <= MB; len++) begin
      for (int k = 0; k < 16; k++) begin
        int n = 2 * len - 1;
        longint nv = (k == 1) ? p10(n) - 1 : (longint'(k) * 7919 + 13 * k * k) % p10(n);
        logic [3:0] sg = (k % 3 == 0) ? 4'hC : (k % 3 == 1) ? 4'hD : 4'hF;
        for (int a = 0; a < 64; a++) begin
          int rk = (k + a) % 4;
          int rnd = (rk == 0) ? 0 : (rk == 1) ? 5 : (rk == 2) ? 9 : 12;
          run_valid(nv, len, a, rnd, sg, '0);
        end
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule